// File: doc/BRIEF.md
# OTP Fuse Controller with Shadow Registers

This block manages a behavioural array of 96 one-time-programmable words of 32 bits. A fuse bit can move from 0 to 1 and never back. Each fuse word has a shadow register that software reads and writes directly. The fuse array changes only when a command runs.

Software talks to the block through a simple 32-bit register port: a write strobe, an address and write data, with read data decoded combinationally from the address. A configuration bit powers the array up or down, and a status register reports the power state. Commands go through a control register. A command can refresh a shadow from its fuse word, OR the staged write data into a fuse word, or set bits in a small permanent-lock table that blocks later programming of chosen words. Each command keeps the block busy for a fixed number of cycles. Status bits report a program failure and a command error. A global lock register can shut off all programming.

Top module: `otp_shadow_ctrl`

## Requirements
- R1: Shadow word n (0..95) is read and written at byte address 0x200 + 4*n. A shadow write changes only that shadow and never the fuse word behind it.
- R2: Register map. Address 0x000 holds the power request in bit 0 and reads back. Address 0x008 holds the staged write data and reads back. Address 0x010 is the global lock: written bits are ORed in and can never be cleared. The control register at 0x004 reads as 0, and unmapped addresses read as 0.
- R3: Status bit 5 (power) takes on the value of the power request exactly PWR_DELAY clock cycles after the request register changes (default 4).
- R4: Status bit 3 (busy) is 1 for exactly BUSY_CYCLES cycles (default 6), starting the cycle after a control write starts a command.
- R5: A control word with bits [9:8] = 00 and index bits [6:0] = n copies fuse word n into shadow n when the command completes.
- R6: A control word with bits [9:8] = 01 ORs the write data, captured when the command starts, into fuse word n. Fuse bits that are already set stay set.
- R7: A control word with bits [9:8] = 11 ORs write-data bits [15:0] into lock-table entry k = bits [6:0] (0..7). Word n < 32 is locked when either bit of the pair at entry n/8, bits 2(n%8)+1 and 2(n%8), is set. Word n ≥ 32 is locked when bit n%16 of entry 4 + (n-32)/16 is set.
- R8: A program command on a locked word leaves the fuse word unchanged and sets status bit 4 (program fail) in the cycle that busy clears.
- R9: While global lock bit 4 is set, program commands (01) and lock commands (11) are ignored: busy does not rise and nothing changes.
- R10: A control write sets status bit 6 (command error) and starts nothing when any of these holds: power status is off, bits [9:8] = 10, the index is 96 or more for a load or program command, or the entry is 8 or more for a lock command.
- R11: A control write while busy is ignored. A write-data change while busy does not alter the program command already running.
- R12: A control write accepted while idle first clears status bits 4 and 6.
- R13: After reset, every register, shadow and status bit reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
The bench measures the power-up delay and the busy window to the exact cycle. A design with an off-by-one counter would show power or idle status one cycle early or late. The bench locks the boundary words 3, 9 (one bit of the pair only), 40 and 95, then programs each of them and a neighbour. A wrong bit or entry formula would either let a locked word change or flag a failure on a free one. It issues a control write and a write-data change while a program is running, which catches a design that restarts, applies a second command or reads the staged data late. It also checks that unpowered and malformed commands, and programming under the global lock, leave every shadow and fuse word untouched.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam logic [11:0] OFF_CFG    = 12'h000;
  localparam logic [11:0] OFF_CTRL   = 12'h004;
  localparam logic [11:0] OFF_WDATA  = 12'h008;
  localparam logic [11:0] OFF_STAT   = 12'h00C;
  localparam logic [11:0] OFF_GLOCK  = 12'h010;
  localparam logic [11:0] OFF_SHADOW = 12'h200;

  localparam int ST_BUSY = 3;
  localparam int ST_FAIL = 4;
  localparam int ST_PWR  = 5;
  localparam int ST_ERR  = 6;
  localparam int GL_PROG = 4;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_PROG  = 2'b01,
    OP_BAD   = 2'b10,
    OP_PLOCK = 2'b11
  } op_e;

endpackage

// File: rtl/otp_power_seq.sv
module otp_power_seq #(
  parameter int PWR_DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic pwr_on
);
  localparam int CW = $clog2(PWR_DELAY + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(PWR_DELAY - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          on_q, on_d;

  always_comb begin
    cnt_d = '0;
    on_d  = on_q;
    if (req != on_q) begin
      if (cnt_q == CNT_LAST) begin
        on_d = req;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      on_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      on_q  <= on_d;
    end
  end

  assign pwr_on = on_q;
endmodule

// File: rtl/otp_lock_table.sv
module otp_lock_table #(
  parameter int WORDS     = 96,
  parameter int LOW_WORDS = 32,
  parameter int LOCK_W    = 16,
  parameter int AW        = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [LOCK_W-1:0] wr_bits,
  output logic [WORDS-1:0]  locked
);
  localparam int PAIRS      = LOCK_W / 2;
  localparam int LOW_ADDRS  = LOW_WORDS / PAIRS;
  localparam int LOCK_ADDRS = LOW_ADDRS + (WORDS - LOW_WORDS + LOCK_W - 1) / LOCK_W;

  logic [LOCK_W-1:0] lock_q [LOCK_ADDRS];

  for (genvar a = 0; a < LOCK_ADDRS; a++) begin : g_entry
    logic              en;
    logic [LOCK_W-1:0] d;
    always_comb begin
      en = wr_en && (wr_addr == AW'(a));
      d  = lock_q[a] | wr_bits;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  lock_q[a] <= '0;
      else if (en) lock_q[a] <= d;
    end
  end

  for (genvar n = 0; n < WORDS; n++) begin : g_word
    if (n < LOW_WORDS) begin : g_pair
      assign locked[n] = |lock_q[n / PAIRS][2*(n % PAIRS) +: 2];
    end else begin : g_single
      assign locked[n] = lock_q[LOW_ADDRS + (n - LOW_WORDS) / LOCK_W][(n - LOW_WORDS) % LOCK_W];
    end
  end
endmodule

// File: rtl/otp_cmd_seq.sv
module otp_cmd_seq
  import otp_pkg::*;
#(
  parameter int BUSY_CYCLES = 6,
  parameter int IDX_W       = 7,
  parameter int WORDS       = 96,
  parameter int LOCK_ADDRS  = 8,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  op_e               cmd_op,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              pwr_on,
  input  logic              prog_block,
  input  logic              target_locked,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              fail,
  output op_e               op_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [DATA_W-1:0] data_q
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0]    CNT_LAST  = CW'(BUSY_CYCLES - 1);
  localparam logic [IDX_W-1:0] WORDS_C   = IDX_W'(WORDS);
  localparam logic [IDX_W-1:0] LOCKS_C   = IDX_W'(LOCK_ADDRS);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d, fail_q, fail_d;
  logic          accept, reject, ignore, start, last;

  always_comb begin
    accept = cmd_wr && !busy_q;
    reject = !pwr_on || (cmd_op == OP_BAD) ||
             ((cmd_op != OP_PLOCK) && (cmd_idx >= WORDS_C)) ||
             ((cmd_op == OP_PLOCK) && (cmd_idx >= LOCKS_C));
    ignore = prog_block && ((cmd_op == OP_PROG) || (cmd_op == OP_PLOCK));
    start  = accept && !reject && !ignore;
    last   = busy_q && (cnt_q == CNT_LAST);

    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (last) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
    end

    err_d  = accept ? reject : err_q;
    fail_d = fail_q;
    if (accept) begin
      fail_d = 1'b0;
    end else if (last && (op_q == OP_PROG) && target_locked) begin
      fail_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      err_q  <= err_d;
      fail_q <= fail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_LOAD;
      idx_q  <= '0;
      data_q <= '0;
    end else if (start) begin
      op_q   <= cmd_op;
      idx_q  <= cmd_idx;
      data_q <= cmd_data;
    end
  end

  assign busy = busy_q;
  assign done = last;
  assign err  = err_q;
  assign fail = fail_q;
endmodule

// File: rtl/otp_shadow_ctrl.sv
module otp_shadow_ctrl
  import otp_pkg::*;
#(
  parameter int WORDS       = 96,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int BUSY_CYCLES = 6,
  parameter int PWR_DELAY   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int IDX_W      = $clog2(WORDS);
  localparam int LOW_WORDS  = 32;
  localparam int LOCK_W     = 16;
  localparam int LOCK_ADDRS = LOW_WORDS / (LOCK_W / 2) + (WORDS - LOW_WORDS + LOCK_W - 1) / LOCK_W;
  localparam int LAW        = $clog2(LOCK_ADDRS);
  localparam int PAD        = (1 << IDX_W) - WORDS;
  localparam logic [ADDR_W-1:0] SH_SPAN = ADDR_W'(4 * WORDS);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // address decode
  logic              hit_cfg, hit_ctrl, hit_wdata, hit_stat, hit_glock, sh_hit;
  logic [ADDR_W-1:0] sh_off;
  logic [IDX_W-1:0]  sh_idx;
  always_comb begin
    hit_cfg   = reg_addr == ADDR_W'(OFF_CFG);
    hit_ctrl  = reg_addr == ADDR_W'(OFF_CTRL);
    hit_wdata = reg_addr == ADDR_W'(OFF_WDATA);
    hit_stat  = reg_addr == ADDR_W'(OFF_STAT);
    hit_glock = reg_addr == ADDR_W'(OFF_GLOCK);
    sh_off    = reg_addr - ADDR_W'(OFF_SHADOW);
    sh_idx    = sh_off[IDX_W+1:2];
    sh_hit    = (reg_addr >= ADDR_W'(OFF_SHADOW)) && (sh_off < SH_SPAN) && (sh_off[1:0] == 2'b00);
  end

  // software registers
  logic              cfg_q, cfg_d, cfg_en;
  logic [DATA_W-1:0] wdata_q, glock_q, glock_d;
  logic              wdata_en, glock_en;
  always_comb begin
    cfg_en   = reg_we && hit_cfg;
    cfg_d    = reg_wdata[0];
    wdata_en = reg_we && hit_wdata;
    glock_en = reg_we && hit_glock;
    glock_d  = glock_q | reg_wdata;
  end
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) cfg_q <= 1'b0;
    else if (cfg_en) cfg_q <= cfg_d;
  end
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) wdata_q <= '0;
    else if (wdata_en) wdata_q <= reg_wdata;
  end
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) glock_q <= '0;
    else if (glock_en) glock_q <= glock_d;
  end

  // power sequencing
  logic pwr_on;
  otp_power_seq #(.PWR_DELAY(PWR_DELAY)) u_pwr (
    .clk(clk), .rst_n(rst_n_i), .req(cfg_q), .pwr_on(pwr_on)
  );

  // command sequencing
  logic              ctrl_wr, busy, done, err, fail, target_locked, prog_block;
  op_e               cmd_op, op_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;
  logic [WORDS-1:0]  locked;
  logic [(1<<IDX_W)-1:0] locked_pad;

  assign ctrl_wr       = reg_we && hit_ctrl;
  assign cmd_op        = op_e'(reg_wdata[9:8]);
  assign prog_block    = glock_q[GL_PROG];
  assign locked_pad    = {{PAD{1'b0}}, locked};
  assign target_locked = locked_pad[idx_q];

  otp_cmd_seq #(
    .BUSY_CYCLES(BUSY_CYCLES), .IDX_W(IDX_W), .WORDS(WORDS),
    .LOCK_ADDRS(LOCK_ADDRS), .DATA_W(DATA_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n_i), .cmd_wr(ctrl_wr), .cmd_op(cmd_op),
    .cmd_idx(reg_wdata[IDX_W-1:0]), .cmd_data(wdata_q), .pwr_on(pwr_on),
    .prog_block(prog_block), .target_locked(target_locked),
    .busy(busy), .done(done), .err(err), .fail(fail),
    .op_q(op_q), .idx_q(idx_q), .data_q(data_q)
  );

  otp_lock_table #(
    .WORDS(WORDS), .LOW_WORDS(LOW_WORDS), .LOCK_W(LOCK_W), .AW(LAW)
  ) u_lock (
    .clk(clk), .rst_n(rst_n_i), .wr_en(done && (op_q == OP_PLOCK)),
    .wr_addr(idx_q[LAW-1:0]), .wr_bits(data_q[LOCK_W-1:0]), .locked(locked)
  );

  // fuse array and shadows
  logic [DATA_W-1:0]       fuse_q   [WORDS];
  logic [DATA_W-1:0]       shadow_q [WORDS];
  logic [WORDS*DATA_W-1:0] fuse_flat;

  for (genvar n = 0; n < WORDS; n++) begin : g_word
    logic              sel, fuse_en, sh_en, sh_load;
    logic [DATA_W-1:0] fuse_d, sh_d;
    always_comb begin
      sel     = idx_q == IDX_W'(n);
      fuse_en = done && (op_q == OP_PROG) && sel && !locked[n];
      fuse_d  = fuse_q[n] | data_q;
      sh_load = done && (op_q == OP_LOAD) && sel;
      sh_en   = sh_load || (reg_we && sh_hit && (sh_idx == IDX_W'(n)));
      sh_d    = sh_load ? fuse_q[n] : reg_wdata;
    end
    always_ff @(posedge clk or negedge rst_n_i) begin
      if (!rst_n_i)     fuse_q[n] <= '0;
      else if (fuse_en) fuse_q[n] <= fuse_d;
    end
    always_ff @(posedge clk or negedge rst_n_i) begin
      if (!rst_n_i)   shadow_q[n] <= '0;
      else if (sh_en) shadow_q[n] <= sh_d;
    end
    assign fuse_flat[n*DATA_W +: DATA_W] = fuse_q[n];
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (hit_cfg) begin
      reg_rdata[0] = cfg_q;
    end else if (hit_wdata) begin
      reg_rdata = wdata_q;
    end else if (hit_stat) begin
      reg_rdata[ST_BUSY] = busy;
      reg_rdata[ST_FAIL] = fail;
      reg_rdata[ST_PWR]  = pwr_on;
      reg_rdata[ST_ERR]  = err;
    end else if (hit_glock) begin
      reg_rdata = glock_q;
    end else if (sh_hit) begin
      for (int n = 0; n < WORDS; n++) begin
        if (sh_idx == IDX_W'(n)) reg_rdata = shadow_q[n];
      end
    end
  end
endmodule

// File: rtl/otp_shadow_ctrl_chk.sv
module otp_shadow_ctrl_chk #(
  parameter int BUSY_CYCLES = 6,
  parameter int FLAT_W      = 3072
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              pwr_on,
  input logic              cfg_req,
  input logic              err,
  input logic              fail,
  input logic              ctrl_wr,
  input logic [1:0]        op_in,
  input logic              prog_block,
  input logic [FLAT_W-1:0] fuse_flat
);
  int busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == BUSY_CYCLES)); // R4
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_len < BUSY_CYCLES)); // R4
  AST_PWR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on != $past(pwr_on)) |-> (pwr_on == $past(cfg_req))); // R3
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy); // R10
  AST_FAIL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $fell(busy)); // R8
  AST_FUSE_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    ((fuse_flat & $past(fuse_flat)) == $past(fuse_flat))); // R6
  AST_GLOCK_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !busy && prog_block && op_in[0]) |=> !busy); // R9
endmodule

bind otp_shadow_ctrl otp_shadow_ctrl_chk #(
  .BUSY_CYCLES(BUSY_CYCLES), .FLAT_W(WORDS*DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n_i), .busy(busy), .pwr_on(pwr_on), .cfg_req(cfg_q),
  .err(err), .fail(fail), .ctrl_wr(ctrl_wr), .op_in(reg_wdata[9:8]),
  .prog_block(prog_block), .fuse_flat(fuse_flat)
);

// File: tb/sim_otp_shadow_ctrl.sv
`timescale 1ns/1ps
module sim_otp_shadow_ctrl;
  localparam int BC = 6;
  localparam int PD = 4;
  localparam int NW = 96;
  localparam logic [11:0] A_CFG = 12'h000, A_CTRL = 12'h004, A_WD = 12'h008,
                          A_ST = 12'h00C, A_GL = 12'h010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  int checks = 0, errors = 0;
  bit cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  otp_shadow_ctrl u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
                      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  // behavioural reference model
  bit [31:0] m_fuse [NW];
  bit [31:0] m_shadow [NW];
  bit [15:0] m_lock [8];
  bit [31:0] m_wdata, m_glock, m_data;
  int m_cfg, m_pwr, m_pcnt, m_busy, m_bcnt, m_op, m_idx, m_err, m_fail;

  function automatic bit m_locked(int n);
    if (n < 32) return ((m_lock[n/8] >> (2*(n%8))) & 16'h3) != 0;
    return m_lock[4 + (n-32)/16][n%16];
  endfunction

  function automatic bit [31:0] m_read(bit [11:0] a);
    bit [31:0] v = 0;
    if (a == A_CFG) v[0] = m_cfg[0];
    else if (a == A_WD) v = m_wdata;
    else if (a == A_ST) begin
      v[3] = m_busy[0]; v[4] = m_fail[0]; v[5] = m_pwr[0]; v[6] = m_err[0];
    end else if (a == A_GL) v = m_glock;
    else if (a >= 12'h200 && a < 12'h200 + 4*NW && a[1:0] == 2'b00) v = m_shadow[(a - 12'h200) / 4];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_fuse[i]) begin m_fuse[i] = 0; m_shadow[i] = 0; end
      foreach (m_lock[i]) m_lock[i] = 0;
      m_wdata = 0; m_glock = 0; m_data = 0;
      m_cfg = 0; m_pwr = 0; m_pcnt = 0; m_busy = 0; m_bcnt = 0;
      m_op = 0; m_idx = 0; m_err = 0; m_fail = 0;
    end else begin
      int o_pwr, o_busy, op, idx;
      bit [31:0] o_glock, o_wdata;
      bit do_load, rej, ign;
      o_pwr = m_pwr; o_busy = m_busy; o_glock = m_glock; o_wdata = m_wdata;
      do_load = 0;
      if (m_cfg != m_pwr) begin
        if (m_pcnt == PD-1) begin m_pwr = m_cfg; m_pcnt = 0; end
        else m_pcnt++;
      end else m_pcnt = 0;
      if (m_busy != 0) begin
        if (m_bcnt == BC-1) begin
          m_busy = 0;
          if (m_op == 0) do_load = 1;
          else if (m_op == 1) begin
            if (m_locked(m_idx)) m_fail = 1;
            else m_fuse[m_idx] |= m_data;
          end else m_lock[m_idx] |= m_data[15:0];
        end else m_bcnt++;
      end
      if (reg_we) begin
        if (reg_addr == A_CFG) m_cfg = reg_wdata[0];
        else if (reg_addr == A_WD) m_wdata = reg_wdata;
        else if (reg_addr == A_GL) m_glock |= reg_wdata;
        else if (reg_addr == A_CTRL) begin
          if (o_busy == 0) begin
            m_err = 0; m_fail = 0;
            op = reg_wdata[9:8]; idx = reg_wdata[6:0];
            rej = (o_pwr == 0) || op == 2 || (op != 3 && idx >= NW) || (op == 3 && idx >= 8);
            ign = (op == 1 || op == 3) && o_glock[4];
            if (rej) m_err = 1;
            else if (!ign) begin
              m_busy = 1; m_bcnt = 0; m_op = op; m_idx = idx; m_data = o_wdata;
            end
          end
        end else if (reg_addr >= 12'h200 && reg_addr < 12'h200 + 4*NW && reg_addr[1:0] == 2'b00)
          m_shadow[(reg_addr - 12'h200) / 4] = reg_wdata;
      end
      if (do_load) m_shadow[m_idx] = m_fuse[m_idx];
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(logic [11:0] a);
    if (a == A_ST) return "R4 status vs model";
    if (a >= 12'h200) return "R1 shadow vs model";
    return "R2 register vs model";
  endfunction

  always @(negedge clk) begin
    if (cmp_en) chk(tag_of(reg_addr), reg_rdata, m_read(reg_addr));
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rdchk(string tag, logic [11:0] a, logic [31:0] exp);
    @(negedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic cmd(logic [31:0] c);
    wr(A_CTRL, c);
    repeat (BC + 1) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;

    // R13 reset state
    rdchk("R13 status", A_ST, 32'h0);
    rdchk("R13 cfg", A_CFG, 32'h0);
    rdchk("R13 shadow0", 12'h200, 32'h0);

    // R2 register map, R10 unpowered command
    wr(A_WD, 32'hA5A5_0F0F);
    rdchk("R2 wdata", A_WD, 32'hA5A5_0F0F);
    wr(A_CTRL, 32'h0000_0001);
    rdchk("R10 unpowered err", A_ST, 32'h40);
    rdchk("R2 ctrl reads 0", A_CTRL, 32'h0);
    rdchk("R2 unmapped", 12'h020, 32'h0);

    // R3 power delay
    @(negedge clk); #1;
    reg_we = 1'b1; reg_addr = A_CFG; reg_wdata = 32'h1;
    @(negedge clk); #1;
    reg_we = 1'b0; reg_addr = A_ST;
    repeat (3) @(negedge clk);
    chk("R3 power still off", reg_rdata & 32'h20, 32'h0);
    @(negedge clk);
    chk("R3 power on after delay", reg_rdata & 32'h20, 32'h20);
    rdchk("R2 cfg readback", A_CFG, 32'h1);

    // R1 shadow access, R5 load
    wr(12'h214, 32'h1234_5678);
    rdchk("R1 shadow5 write", 12'h214, 32'h1234_5678);
    cmd(32'h0000_0005);
    rdchk("R5 load of blank fuse", 12'h214, 32'h0);

    // R4 busy window on a program
    wr(A_WD, 32'h0000_00F0);
    @(negedge clk); #1;
    reg_we = 1'b1; reg_addr = A_CTRL; reg_wdata = 32'h0000_0105;
    @(negedge clk); #1;
    reg_we = 1'b0; reg_addr = A_ST;
    repeat (5) @(negedge clk);
    chk("R4 busy last cycle", reg_rdata & 32'h8, 32'h8);
    @(negedge clk);
    chk("R4 busy cleared", reg_rdata & 32'h8, 32'h0);
    cmd(32'h0000_0005);
    rdchk("R5 load after program", 12'h214, 32'h0000_00F0);

    // R6 OR programming, R1 shadow write leaves fuse alone
    wr(A_WD, 32'h0F00_0000);
    cmd(32'h0000_0105);
    wr(12'h214, 32'hFFFF_FFFF);
    cmd(32'h0000_0005);
    rdchk("R6 OR into fuse / R1 no fuse touch", 12'h214, 32'h0F00_00F0);

    // R11 writes during busy
    wr(12'h21C, 32'hDEAD_0007);
    wr(A_WD, 32'h0000_0001);
    wr(A_CTRL, 32'h0000_0106);
    wr(A_WD, 32'h0000_0002);
    wr(A_CTRL, 32'h0000_0007);
    repeat (BC) @(negedge clk);
    rdchk("R11 no err from busy write", A_ST, 32'h20);
    cmd(32'h0000_0006);
    rdchk("R11 captured data", 12'h218, 32'h0000_0001);
    rdchk("R11 second cmd dropped", 12'h21C, 32'hDEAD_0007);

    // R7 lock words 3, 9, 40, 95; R8 program fails
    wr(A_WD, 32'h0000_00C0); cmd(32'h0000_0300);
    wr(A_WD, 32'h0000_0004); cmd(32'h0000_0301);
    wr(A_WD, 32'h0000_0100); cmd(32'h0000_0304);
    wr(A_WD, 32'h0000_8000); cmd(32'h0000_0307);
    wr(A_WD, 32'h0000_00AA);
    cmd(32'h0000_0103);
    rdchk("R8 fail word3", A_ST, 32'h30);
    cmd(32'h0000_0003);
    rdchk("R12 load clears fail", A_ST, 32'h20);
    rdchk("R8 word3 unchanged", 12'h20C, 32'h0);
    cmd(32'h0000_0102);
    rdchk("R7 word2 free", A_ST, 32'h20);
    cmd(32'h0000_0109);
    rdchk("R7 word9 single pair bit", A_ST, 32'h30);
    cmd(32'h0000_0128);
    rdchk("R7 word40 locked", A_ST, 32'h30);
    cmd(32'h0000_0129);
    rdchk("R7 word41 free", A_ST, 32'h20);
    cmd(32'h0000_015F);
    rdchk("R7 word95 locked", A_ST, 32'h30);
    cmd(32'h0000_0029);
    rdchk("R7 word41 programmed", 12'h2A4, 32'h0000_00AA);

    // R10 malformed commands
    wr(A_CTRL, 32'h0000_0200);
    rdchk("R10 cmd 10", A_ST, 32'h60 & 32'h60);
    wr(A_CTRL, 32'h0000_0060);
    rdchk("R10 index 96", A_ST, 32'h60);
    wr(A_CTRL, 32'h0000_0308);
    rdchk("R10 lock entry 8", A_ST, 32'h60);
    wr(A_CFG, 32'h0);
    repeat (PD + 2) @(negedge clk);
    wr(A_CTRL, 32'h0000_0102);
    rdchk("R10 power off", A_ST, 32'h40);
    wr(A_CFG, 32'h1);
    repeat (PD + 2) @(negedge clk);

    // R9 global lock
    wr(A_GL, 32'h0000_0010);
    wr(A_WD, 32'h0000_FFFF);
    wr(A_CTRL, 32'h0000_0102);
    rdchk("R9 no busy", A_ST, 32'h20);
    cmd(32'h0000_0002);
    rdchk("R9 word2 unchanged", 12'h208, 32'h0000_00AA);
    wr(A_GL, 32'h0);
    rdchk("R2 glock sticky", A_GL, 32'h0000_0010);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule